// File: doc/BRIEF.md
# Dual-Issue Class Steering Unit

This unit sits between instruction fetch and two execution ports. Each cycle it looks at an aligned pair of fetched words. Every word arrives with a one-bit class tag, set before the word was stored in the instruction cache, that marks it as a floating-point ALU operation or as any other kind. The unit also receives a three-bit resource code for each word. Per cycle, at most one word of each class leaves, in program order. A floating-point word goes to the FP port and any other word goes to the integer port. When both words of the pair carry the same class, the older word leaves first and the younger word leaves one cycle later.

Two execution resources are not pipelined, and the unit tracks both of them. The integer multiply/divide unit stays busy for a fixed number of cycles, and that number depends on the opcode. The unit counts those cycles itself. The floating-point divide/square-root unit stays busy until its done pulse arrives. A word that needs a busy resource waits in place. Every younger word waits behind it, so issue never reorders and never speculates.

The fetch-advance output rises once every eligible word of the current pair has left. That output tells fetch to present the next pair. A start-slot input marks a pair whose first word must be skipped, as happens on a branch to the second word of a pair.

Top module: `dual_issue_steer`

## Requirements
- R1: While reset is held and no pair is valid, both issue-valid outputs are 0 and fetchAdvance is 1.
- R2: When both words of a pair are eligible, their class tags differ, and neither needs a busy resource, both words issue in the same cycle. This holds whichever word carries the FP tag (tag 1 = floating-point ALU, tag 0 = other).
- R3: When both words of a pair carry the same class tag, word 0 issues in one cycle and word 1 issues in the next cycle. fetchAdvance is 0 in the first of those cycles.
- R4: With startSlot = 1, word 0 of the pair is never issued and word 1 alone is eligible.
- R5: While pairValid = 0, neither port issues and fetchAdvance is 1.
- R6: fetchAdvance is 1 exactly in the cycle by whose end every eligible word of the held pair has issued. A word issued in an earlier cycle is not issued again.
- R7: Resource codes 1, 2, 3 and 4 (32-bit multiply, 64-bit multiply, 32-bit divide, 64-bit divide) occupy the multiply/divide unit. Another such word issues no sooner than 8, 12, 36 and 68 cycles later respectively, and it issues exactly then if it is waiting at that point.
- R8: Resource code 5 (FP divide or square root) marks the FP long unit busy. The next code-5 word issues in the cycle after the fpDone pulse.
- R9: A word held back for a busy resource or for a class already used also holds back the younger word of the pair.
- R10: A word with class tag 1 appears on the FP port and a word with class tag 0 appears on the integer port. Its instruction bits pass through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pairValid | input | 1 | The fetched pair is valid |
| startSlot | input | 1 | 1: word 0 is skipped (branch target is word 1) |
| instr0 | input | DATA_W | Instruction bits of word 0 (older) |
| isFp0 | input | 1 | Class tag of word 0, 1 = floating-point ALU |
| res0 | input | 3 | Resource code of word 0 |
| instr1 | input | DATA_W | Instruction bits of word 1 (younger) |
| isFp1 | input | 1 | Class tag of word 1 |
| res1 | input | 3 | Resource code of word 1 |
| fpDone | input | 1 | Pulse: the FP divide/square-root unit has finished |
| intValid | output | 1 | A word issues on the integer port this cycle |
| intInstr | output | DATA_W | Instruction on the integer port |
| fpValid | output | 1 | A word issues on the FP port this cycle |
| fpInstr | output | DATA_W | Instruction on the FP port |
| fetchAdvance | output | 1 | The held pair is fully consumed; fetch may present the next pair |

## Verification
The assertions rely on three things about the inputs:
- A pair stays stable until fetchAdvance is seen.
- Codes 1 to 4 appear only on words tagged 0, and code 5 appears only on words tagged 1.
- fpDone pulses only while an FP long operation is outstanding.

The stimulus keeps within these rules. It drives every input from a program queue that it pops only on the cycle the reference model predicts an advance. It draws resource codes from the set allowed for the chosen class. It raises fpDone a set number of cycles after each code-5 issue.

// File: rtl/steer_pkg.sv
package steer_pkg;

  typedef enum logic [2:0] {
    RES_NONE   = 3'd0,
    RES_MULT   = 3'd1,
    RES_DMULT  = 3'd2,
    RES_DIV    = 3'd3,
    RES_DDIV   = 3'd4,
    RES_FPLONG = 3'd5
  } resCode_e;

  // strobes from control to the routing datapath
  typedef struct packed {
    logic intValid;
    logic intFrom1;
    logic fpValid;
    logic fpFrom1;
  } routeStrobe_t;

  function automatic logic usesMuldiv(input logic [2:0] code);
    return (code == RES_MULT) || (code == RES_DMULT) ||
           (code == RES_DIV)  || (code == RES_DDIV);
  endfunction

endpackage

// File: rtl/steer_ctrl.sv
module steer_ctrl
  import steer_pkg::*;
#(
  parameter int LAT_MULT  = 8,
  parameter int LAT_DMULT = 12,
  parameter int LAT_DIV   = 36,
  parameter int LAT_DDIV  = 68
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pairValid,
  input  logic         startSlot,
  input  logic         isFp0,
  input  logic         isFp1,
  input  logic [2:0]   res0,
  input  logic [2:0]   res1,
  input  logic         fpDone,
  output routeStrobe_t strobe,
  output logic         fetchAdvance
);

  localparam int MAX_A   = (LAT_MULT > LAT_DMULT) ? LAT_MULT : LAT_DMULT;
  localparam int MAX_B   = (LAT_DIV > LAT_DDIV) ? LAT_DIV : LAT_DDIV;
  localparam int MAX_LAT = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W   = $clog2(MAX_LAT + 1);

  logic             done0, done1, fpBusy;
  logic [CNT_W-1:0] mdCnt, mdLoad;
  logic             elig0, elig1, md0, md1, fpl0, fpl1, ok0, ok1;
  logic             fire0, fire1, clash, fireMd, fireFpl;
  logic [2:0]       mdCode;

  always_comb begin
    md0   = usesMuldiv(res0);
    md1   = usesMuldiv(res1);
    fpl0  = (res0 == RES_FPLONG);
    fpl1  = (res1 == RES_FPLONG);
    elig0 = pairValid && !startSlot && !done0;
    elig1 = pairValid && !done1;
    ok0   = md0 ? (mdCnt == '0) : (fpl0 ? !fpBusy : 1'b1);
    ok1   = md1 ? (mdCnt == '0) : (fpl1 ? !fpBusy : 1'b1);
    clash = (md0 && md1) || (fpl0 && fpl1);
    fire0 = elig0 && ok0;
    // younger word only goes alongside the older one or once it is gone
    fire1 = elig1 && ok1 &&
            (!elig0 || (fire0 && (isFp0 != isFp1) && !clash));
    fetchAdvance = (!elig0 || fire0) && (!elig1 || fire1);

    fireMd  = (fire0 && md0) || (fire1 && md1);
    mdCode  = (fire0 && md0) ? res0 : res1;
    fireFpl = (fire0 && fpl0) || (fire1 && fpl1);

    strobe.fpValid  = (fire0 && isFp0) || (fire1 && isFp1);
    strobe.fpFrom1  = fire1 && isFp1;
    strobe.intValid = (fire0 && !isFp0) || (fire1 && !isFp1);
    strobe.intFrom1 = fire1 && !isFp1;
  end

  always_comb begin
    case (mdCode)
      RES_MULT:  mdLoad = CNT_W'(LAT_MULT - 1);
      RES_DMULT: mdLoad = CNT_W'(LAT_DMULT - 1);
      RES_DIV:   mdLoad = CNT_W'(LAT_DIV - 1);
      RES_DDIV:  mdLoad = CNT_W'(LAT_DDIV - 1);
      default:   mdLoad = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done0  <= 1'b0;
      done1  <= 1'b0;
      fpBusy <= 1'b0;
      mdCnt  <= '0;
    end else begin
      if (fetchAdvance) begin
        done0 <= 1'b0;
        done1 <= 1'b0;
      end else begin
        done0 <= done0 | fire0;
        done1 <= done1 | fire1;
      end
      if (fireFpl)     fpBusy <= 1'b1;
      else if (fpDone) fpBusy <= 1'b0;
      if (fireMd)              mdCnt <= mdLoad;
      else if (mdCnt != '0)    mdCnt <= mdCnt - 1'b1;
    end
  end

  p_md_repeat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fireMd |=> !fireMd);

  p_fp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fireFpl |=> !fireFpl);

  p_in_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fire1 && elig0) |-> fire0);

  p_class_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fire0 && fire1) |-> (isFp0 != isFp1));

  p_skip_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    startSlot |-> !fire0);

  p_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !pairValid |-> (!fire0 && !fire1 && fetchAdvance));

endmodule

// File: rtl/steer_route.sv
module steer_route
  import steer_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  routeStrobe_t      strobe,
  input  logic [DATA_W-1:0] instr0,
  input  logic [DATA_W-1:0] instr1,
  output logic              intValid,
  output logic [DATA_W-1:0] intInstr,
  output logic              fpValid,
  output logic [DATA_W-1:0] fpInstr
);

  always_comb begin
    intValid = strobe.intValid;
    fpValid  = strobe.fpValid;
    intInstr = strobe.intValid ? (strobe.intFrom1 ? instr1 : instr0) : '0;
    fpInstr  = strobe.fpValid  ? (strobe.fpFrom1  ? instr1 : instr0) : '0;
  end

  p_port_excl_r10: assert final (!(strobe.intFrom1 && strobe.fpFrom1));

endmodule

// File: rtl/dual_issue_steer.sv
module dual_issue_steer
  import steer_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int LAT_MULT  = 8,
  parameter int LAT_DMULT = 12,
  parameter int LAT_DIV   = 36,
  parameter int LAT_DDIV  = 68
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pairValid,
  input  logic              startSlot,
  input  logic [DATA_W-1:0] instr0,
  input  logic              isFp0,
  input  logic [2:0]        res0,
  input  logic [DATA_W-1:0] instr1,
  input  logic              isFp1,
  input  logic [2:0]        res1,
  input  logic              fpDone,
  output logic              intValid,
  output logic [DATA_W-1:0] intInstr,
  output logic              fpValid,
  output logic [DATA_W-1:0] fpInstr,
  output logic              fetchAdvance
);

  routeStrobe_t strobe;

  steer_ctrl #(
    .LAT_MULT(LAT_MULT), .LAT_DMULT(LAT_DMULT),
    .LAT_DIV(LAT_DIV),   .LAT_DDIV(LAT_DDIV)
  ) i_ctrl (
    .clk(clk), .rst_n(rst_n), .pairValid(pairValid), .startSlot(startSlot),
    .isFp0(isFp0), .isFp1(isFp1), .res0(res0), .res1(res1),
    .fpDone(fpDone), .strobe(strobe), .fetchAdvance(fetchAdvance)
  );

  steer_route #(.DATA_W(DATA_W)) i_route (
    .strobe(strobe), .instr0(instr0), .instr1(instr1),
    .intValid(intValid), .intInstr(intInstr),
    .fpValid(fpValid), .fpInstr(fpInstr)
  );

endmodule

// File: tb/test_dual_issue_steer.sv
module test_dual_issue_steer;

  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pairValid = 1'b0, startSlot = 1'b0;
  logic [DW-1:0] instr0 = '0, instr1 = '0;
  logic          isFp0 = 1'b0, isFp1 = 1'b0;
  logic [2:0]    res0 = '0, res1 = '0;
  logic          fpDone = 1'b0;
  logic          intValid, fpValid, fetchAdvance;
  logic [DW-1:0] intInstr, fpInstr;

  always #4 clk = ~clk;

  dual_issue_steer #(.DATA_W(DW)) i_dual_issue_steer (
    .clk(clk), .rst_n(rst_n), .pairValid(pairValid), .startSlot(startSlot),
    .instr0(instr0), .isFp0(isFp0), .res0(res0),
    .instr1(instr1), .isFp1(isFp1), .res1(res1),
    .fpDone(fpDone), .intValid(intValid), .intInstr(intInstr),
    .fpValid(fpValid), .fpInstr(fpInstr), .fetchAdvance(fetchAdvance)
  );

  typedef struct {
    bit        v;
    bit        slot;
    bit [31:0] id0;
    bit        f0;
    bit [2:0]  r0;
    bit [31:0] id1;
    bit        f1;
    bit [2:0]  r1;
  } pair_t;

  pair_t  prog[$];
  int     checks = 0, failures = 0, cycle = 0;
  int     mdFreeAt = 0, doneAt = -1, fpDelay = 4;
  bit     fpBusyM = 0, randDelay = 0, finished = 0;
  bit     mDone[2] = '{0, 0};
  int     issCyc[int];
  int     doneLog[$];
  string  tag = "R1";

  function automatic int latOf(bit [2:0] r);
    case (r)
      3'd1: return 8;
      3'd2: return 12;
      3'd3: return 36;
      3'd4: return 68;
      default: return 0;
    endcase
  endfunction

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h (cycle %0d)", tag, what, act, exp, cycle);
    end
  endtask

  function automatic void addPair(bit slot, bit f0, bit [2:0] r0, int i0,
                                  bit f1, bit [2:0] r1, int i1);
    pair_t p;
    p.v = 1; p.slot = slot;
    p.f0 = f0; p.r0 = r0; p.id0 = i0;
    p.f1 = f1; p.r1 = r1; p.id1 = i1;
    prog.push_back(p);
  endfunction

  function automatic void addIdle();
    pair_t p;
    p.v = 0; p.slot = 0; p.f0 = 0; p.r0 = 0; p.id0 = 0;
    p.f1 = 0; p.r1 = 0; p.id1 = 0;
    prog.push_back(p);
  endfunction

  task automatic cycleStep();
    pair_t     p;
    bit        have, pv, blocked, usedF, usedI, clMd, clFp, ok, expAdv;
    bit        expIV, expFV;
    bit [31:0] expII, expFI;
    bit        elig[2], iss[2], f[2];
    bit [2:0]  r[2];
    bit [31:0] id[2];
    @(negedge clk);
    have = (prog.size() > 0);
    if (have) p = prog[0];
    else begin
      p.v = 0; p.slot = 0; p.f0 = 0; p.r0 = 0; p.id0 = 0;
      p.f1 = 0; p.r1 = 0; p.id1 = 0;
    end
    pv = have && p.v;
    pairValid = pv; startSlot = p.slot;
    instr0 = p.id0; isFp0 = p.f0; res0 = p.r0;
    instr1 = p.id1; isFp1 = p.f1; res1 = p.r1;
    fpDone = (cycle == doneAt);
    #1;
    // reference model: walk the pair in program order
    f[0] = p.f0; f[1] = p.f1; r[0] = p.r0; r[1] = p.r1; id[0] = p.id0; id[1] = p.id1;
    blocked = 0; usedF = 0; usedI = 0; clMd = 0; clFp = 0;
    expIV = 0; expFV = 0; expII = 0; expFI = 0;
    for (int k = 0; k < 2; k++) begin
      elig[k] = pv && !(k == 0 && p.slot) && !mDone[k];
      iss[k] = 0;
      if (elig[k] && !blocked) begin
        ok = 1;
        if (f[k] ? usedF : usedI) ok = 0;
        if (latOf(r[k]) != 0 && (cycle < mdFreeAt || clMd)) ok = 0;
        if (r[k] == 3'd5 && (fpBusyM || clFp)) ok = 0;
        if (ok) begin
          iss[k] = 1;
          if (f[k]) begin usedF = 1; expFV = 1; expFI = id[k]; end
          else begin usedI = 1; expIV = 1; expII = id[k]; end
          if (latOf(r[k]) != 0) clMd = 1;
          if (r[k] == 3'd5) clFp = 1;
        end else blocked = 1;
      end
    end
    expAdv = (!elig[0] || iss[0]) && (!elig[1] || iss[1]);

    chk("R10 intValid", {31'd0, intValid}, {31'd0, expIV});
    chk("R10 fpValid", {31'd0, fpValid}, {31'd0, expFV});
    if (expIV) chk("R10 intInstr", intInstr, expII);
    if (expFV) chk("R10 fpInstr", fpInstr, expFI);
    chk("R6 fetchAdvance", {31'd0, fetchAdvance}, {31'd0, expAdv});

    if (intValid) issCyc[int'(intInstr)] = cycle;
    if (fpValid)  issCyc[int'(fpInstr)]  = cycle;

    // model state update for the coming edge
    if (fpDone) begin
      fpBusyM = 0;
      doneLog.push_back(cycle);
    end
    for (int k = 0; k < 2; k++) begin
      if (iss[k] && r[k] == 3'd5) begin
        fpBusyM = 1;
        if (randDelay) fpDelay = 1 + int'($urandom % 8);
        doneAt = cycle + fpDelay;
      end
      if (iss[k] && latOf(r[k]) != 0) mdFreeAt = cycle + latOf(r[k]);
    end
    if (expAdv) begin mDone[0] = 0; mDone[1] = 0; end
    else begin mDone[0] = mDone[0] | iss[0]; mDone[1] = mDone[1] | iss[1]; end
    if (expAdv && have) void'(prog.pop_front());
    cycle++;
  endtask

  task automatic runAll();
    while (prog.size() > 0 && !finished) cycleStep();
    cycleStep();
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    int nid;
    bit fr, fa;
    bit [2:0] rr, ra;
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    chk("R1 intValid in reset", {31'd0, intValid}, 32'd0);
    chk("R1 fpValid in reset", {31'd0, fpValid}, 32'd0);
    chk("R1 fetchAdvance in reset", {31'd0, fetchAdvance}, 32'd1);
    rst_n = 1'b1;

    tag = "R2";
    addPair(0, 0, 3'd0, 'h100, 1, 3'd0, 'h101);
    addPair(0, 1, 3'd0, 'h102, 0, 3'd0, 'h103);
    runAll();
    chk("R2 int/fp same cycle", issCyc['h101], issCyc['h100]);
    chk("R2 fp/int same cycle", issCyc['h103], issCyc['h102]);

    tag = "R3";
    addPair(0, 0, 3'd0, 'h110, 0, 3'd0, 'h111);
    addPair(0, 1, 3'd0, 'h112, 1, 3'd0, 'h113);
    runAll();
    chk("R3 int pair split", issCyc['h111], issCyc['h110] + 1);
    chk("R3 fp pair split", issCyc['h113], issCyc['h112] + 1);

    tag = "R4";
    addPair(1, 0, 3'd0, 'h120, 0, 3'd0, 'h121);
    runAll();
    chk("R4 word0 skipped", {31'd0, issCyc.exists('h120)}, 32'd0);
    chk("R4 word1 issued", {31'd0, issCyc.exists('h121)}, 32'd1);

    tag = "R5";
    addIdle(); addIdle(); addIdle();
    addPair(0, 0, 3'd0, 'h130, 1, 3'd0, 'h131);
    runAll();

    tag = "R7";
    for (int c = 1; c <= 4; c++) begin
      addPair(0, 0, 3'(c), 'h200 + c, 1, 3'd0, 'h210 + c);
      addPair(0, 0, 3'(c), 'h220 + c, 1, 3'd0, 'h230 + c);
      runAll();
      chk("R7 muldiv repeat interval", issCyc['h220 + c] - issCyc['h200 + c],
          latOf(3'(c)));
      chk("R9 younger fp word held", issCyc['h230 + c], issCyc['h220 + c]);
    end

    tag = "R8";
    doneLog.delete();
    fpDelay = 5;
    addPair(0, 1, 3'd5, 'h300, 0, 3'd0, 'h301);
    addPair(0, 1, 3'd5, 'h302, 0, 3'd0, 'h303);
    runAll();
    repeat (8) cycleStep();
    chk("R8 done pulse timing", doneLog[0], issCyc['h300] + 5);
    chk("R8 second fp long after done", issCyc['h302], doneLog[0] + 1);
    chk("R9 younger int word held", issCyc['h303], issCyc['h302]);

    tag = "R9";
    randDelay = 1;
    nid = 'h1000;
    for (int n = 0; n < 300; n++) begin
      if ($urandom % 10 == 0) addIdle();
      else begin
        fr = 1'($urandom % 2);
        fa = 1'($urandom % 2);
        rr = fr ? (($urandom % 6 == 0) ? 3'd5 : 3'd0)
                : (($urandom % 8 == 0) ? 3'(1 + $urandom % 4) : 3'd0);
        ra = fa ? (($urandom % 6 == 0) ? 3'd5 : 3'd0)
                : (($urandom % 8 == 0) ? 3'(1 + $urandom % 4) : 3'd0);
        addPair(1'($urandom % 7 == 0), fr, rr, nid, fa, ra, nid + 1);
        nid += 2;
      end
    end
    runAll();

    if (!finished) begin
      finished = 1;
      summary();
      $finish;
    end
  end

  initial begin
    #(8 * 190000);
    if (!finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog %s actual=hung expected=done", tag);
      summary();
      $finish;
    end
  end

endmodule